// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits in front of a bank of 16-bit counter channels, grouped three to a counter chip, and picks the clock and the gate that each channel sees. For each channel, software writes a 5-bit clock code and a 5-bit gate code. The clock can come from several places: the channel's own clock pin, the chip's shared external clock pin, a ladder of internal rates derived from the 20 MHz reference, fixed levels, a pattern-present flag, or the output of a neighbouring channel. The gate can be always on, always off, the gate pin in either polarity, a neighbour's output in either polarity, or one of three pattern status signals in either polarity.

The whole block runs on the 20 MHz reference clock. Pin-derived clock selections pass through as levels. Internal rates come out as enables one reference cycle wide. The neighbour links close into a ring across the chips, so the last chip feeds the first.

Two pattern status flags are kept in registers. Pattern-occurred goes high once the pattern has been seen. Pattern-gone-away drops low once the pattern has left after having occurred. A synchronous clear input resets both flags. For each channel the block also reports whether its clock pin and its gate pin should be driven as outputs. The counters and the pattern comparator are outside this block.

Top module: `ctr_src_router`

## Requirements
- R1: Clock code 0 passes the channel's own clock pin. Clock code 7 passes the external clock pin shared by that channel's chip, where chip = channel / 3.
- R2: Clock codes 1 to 5 give one-cycle pulses with periods, in reference cycles, of 2, 20, 200, 2000 and 20000 respectively.
- R3: Clock code 8 gives constant 1. Code 9 gives constant 0. Code 10 gives the pattern-present input. Code 11 gives the 20 MHz rate, which is high on every reference cycle.
- R4: Every clock code from 12 to 31 gives 0. Gate codes 4, 5 and 14 to 31 give 0.
- R5: Gate code 0 gives 1, code 1 gives 0, and code 2 passes the channel's gate pin.
- R6: Gate code 6 gives the inverted gate pin.
- R7: Gate codes 8, 9 and 10 give pattern-present, pattern-occurred and pattern-gone-away. Gate codes 11, 12 and 13 give the inversion of each of those three.
- R8: Clock code 6 selects the OUT of a neighbour. For a channel at position k>0 within its chip, the neighbour is the previous channel on the same chip. For position 0, it is position 2 of the preceding chip, and chip 0 is preceded by the last chip.
- R9: Gate code 3 gives the inverted OUT of a second neighbour, and gate code 7 gives that same OUT without inversion. For position 2, the second neighbour is position 0 of the same chip. For positions 0 and 1, it is position k+1 of the preceding chip, with the ring wrapping the same way as in R8.
- R10: Pattern-occurred rises one clock edge after pattern-present is sampled high, and it then holds high until it is cleared.
- R11: Pattern-gone-away starts high. It falls one edge after pattern-present is sampled low while pattern-occurred is high. Once low, it stays low until it is cleared, even if the pattern returns.
- R12: A clear sampled high returns pattern-occurred to 0 and pattern-gone-away to 1 on that same edge. The clear takes priority over a pattern-present that is high at the same time.
- R13: A channel's clock pin output enable is high exactly when its clock code is not 0. Its gate pin output enable is high exactly when its gate code is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 20 MHz reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | NUM_CHIPS*3*CODE_W | Clock code per channel, channel c at [c*CODE_W +: CODE_W] |
| gat_sel_i | input | NUM_CHIPS*3*CODE_W | Gate code per channel, same packing |
| clk_pin_i | input | NUM_CHIPS*3 | Dedicated clock pin per channel |
| gat_pin_i | input | NUM_CHIPS*3 | Dedicated gate pin per channel |
| ext_clk_i | input | NUM_CHIPS | Shared external clock pin per chip |
| ctr_out_i | input | NUM_CHIPS*3 | OUT of each counter channel |
| pat_present_i | input | 1 | Pattern-present flag |
| pat_clr_i | input | 1 | Synchronous clear of both pattern flags |
| cnt_clk_o | output | NUM_CHIPS*3 | Selected clock per channel |
| cnt_gate_o | output | NUM_CHIPS*3 | Selected gate per channel |
| clk_pin_oe_o | output | NUM_CHIPS*3 | Drive enable for each clock pin |
| gat_pin_oe_o | output | NUM_CHIPS*3 | Drive enable for each gate pin |

## Verification
The bench puts a one-hot pattern on the counter outputs and sweeps it over every channel. A ring that does not wrap, or that wraps in the wrong direction, then lights the wrong clock or gate, and this shows first on positions 0 and 1 of chip 0. The period of each rate is measured across two successive pulses, so a divider that is off by one shows up as a wrong count. The pattern flags are driven through appear, leave and return, and through a clear that arrives while the pattern is still present. A latch that re-arms, fails to hold, or lets a set win over the clear then shows the wrong level on the cycle right after the edge. Reserved codes are applied with every pin held high, so a decoder that leaks a pin into an unused slot gives a 1 where 0 is expected.

// File: rtl/ctr_src_pkg.sv
package ctr_src_pkg;
   localparam int unsigned CHANS_PER_CHIP = 3;
   localparam int unsigned MAX_RATES      = 5;

   typedef enum logic [4:0] {
      CK_PIN   = 5'd0,
      CK_PREV  = 5'd6,
      CK_EXT   = 5'd7,
      CK_HIGH  = 5'd8,
      CK_LOW   = 5'd9,
      CK_PAT   = 5'd10,
      CK_REF   = 5'd11
   } clk_code_e;

   typedef enum logic [4:0] {
      GT_ON    = 5'd0,
      GT_OFF   = 5'd1,
      GT_PIN   = 5'd2,
      GT_NOUT2 = 5'd3,
      GT_NPIN  = 5'd6,
      GT_OUT2  = 5'd7,
      GT_PAT   = 5'd8,
      GT_OCC   = 5'd9,
      GT_GONE  = 5'd10,
      GT_NPAT  = 5'd11,
      GT_NOCC  = 5'd12,
      GT_NGONE = 5'd13
   } gate_code_e;
endpackage

// File: rtl/ctr_rate_gen.sv
module ctr_rate_gen #(
   parameter int unsigned FIRST_DIV   = 2,
   parameter int unsigned DECADE_DIV  = 10,
   parameter int unsigned NUM_DECADES = 4,
   localparam int unsigned NUM_RATES  = NUM_DECADES + 1
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   output logic [NUM_RATES-1:0] tick_o
);
   logic [NUM_RATES:0] chain;
   assign chain[0] = 1'b1;

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_stage
      localparam int unsigned DIV = (i == 0) ? FIRST_DIV : DECADE_DIV;
      localparam int unsigned CW  = (DIV > 2) ? $clog2(DIV) : 1;
      logic [CW-1:0] cnt_q;
      logic          wrap;

      assign wrap = (cnt_q == CW'(DIV - 1));

      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i)      cnt_q <= '0;
         else if (chain[i]) cnt_q <= wrap ? '0 : cnt_q + CW'(1);
      end

      assign chain[i+1] = chain[i] & wrap;
      assign tick_o[i]  = chain[i+1];
   end
endmodule

// File: rtl/ctr_pat_latch.sv
module ctr_pat_latch (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic pat_present_i,
   input  logic clr_i,
   output logic occ_o,
   output logic left_o
);
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         occ_o  <= 1'b0;
         left_o <= 1'b0;
      end else if (clr_i) begin
         occ_o  <= 1'b0;
         left_o <= 1'b0;
      end else begin
         if (pat_present_i)           occ_o  <= 1'b1;
         if (occ_o && !pat_present_i) left_o <= 1'b1;
      end
   end
endmodule

// File: rtl/ctr_chan_mux.sv
module ctr_chan_mux
   import ctr_src_pkg::*;
#(
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned NUM_RATES = 5,
   parameter bit          ENHANCED  = 1'b1
) (
   input  logic [CODE_W-1:0]    clk_sel_i,
   input  logic [CODE_W-1:0]    gat_sel_i,
   input  logic                 pin_clk_i,
   input  logic                 pin_gat_i,
   input  logic                 ext_clk_i,
   input  logic                 prev_out_i,
   input  logic                 prev2_out_i,
   input  logic [NUM_RATES-1:0] rate_tick_i,
   input  logic                 pat_present_i,
   input  logic                 pat_occ_i,
   input  logic                 pat_gone_n_i,
   output logic                 clk_o,
   output logic                 gate_o,
   output logic                 clk_oe_o,
   output logic                 gat_oe_o
);
   logic clk_base, gate_base, clk_ext, gate_ext;

   always_comb begin
      clk_base = 1'b0;
      case (clk_sel_i)
         CODE_W'(CK_PIN):  clk_base = pin_clk_i;
         CODE_W'(CK_PREV): clk_base = prev_out_i;
         CODE_W'(CK_EXT):  clk_base = ext_clk_i;
         default:          clk_base = 1'b0;
      endcase
      for (int r = 0; r < NUM_RATES; r++) begin
         if (clk_sel_i == CODE_W'(r + 1)) clk_base = rate_tick_i[r];
      end
   end

   always_comb begin
      case (gat_sel_i)
         CODE_W'(GT_ON):    gate_base = 1'b1;
         CODE_W'(GT_PIN):   gate_base = pin_gat_i;
         CODE_W'(GT_NOUT2): gate_base = ~prev2_out_i;
         default:           gate_base = 1'b0;
      endcase
   end

   if (ENHANCED) begin : g_enh
      always_comb begin
         case (clk_sel_i)
            CODE_W'(CK_HIGH): clk_ext = 1'b1;
            CODE_W'(CK_PAT):  clk_ext = pat_present_i;
            CODE_W'(CK_REF):  clk_ext = 1'b1;
            default:          clk_ext = 1'b0;
         endcase
      end
      always_comb begin
         case (gat_sel_i)
            CODE_W'(GT_NPIN):  gate_ext = ~pin_gat_i;
            CODE_W'(GT_OUT2):  gate_ext = prev2_out_i;
            CODE_W'(GT_PAT):   gate_ext = pat_present_i;
            CODE_W'(GT_OCC):   gate_ext = pat_occ_i;
            CODE_W'(GT_GONE):  gate_ext = pat_gone_n_i;
            CODE_W'(GT_NPAT):  gate_ext = ~pat_present_i;
            CODE_W'(GT_NOCC):  gate_ext = ~pat_occ_i;
            CODE_W'(GT_NGONE): gate_ext = ~pat_gone_n_i;
            default:           gate_ext = 1'b0;
         endcase
      end
   end else begin : g_base
      assign clk_ext  = 1'b0;
      assign gate_ext = 1'b0;
   end

   assign clk_o    = clk_base | clk_ext;
   assign gate_o   = gate_base | gate_ext;
   assign clk_oe_o = (clk_sel_i != CODE_W'(CK_PIN));
   assign gat_oe_o = (gat_sel_i != CODE_W'(GT_PIN));
endmodule

// File: rtl/ctr_src_router.sv
module ctr_src_router
   import ctr_src_pkg::*;
#(
   parameter int unsigned NUM_CHIPS   = 2,
   parameter int unsigned CODE_W      = 5,
   parameter int unsigned FIRST_DIV   = 2,
   parameter int unsigned DECADE_DIV  = 10,
   parameter int unsigned NUM_DECADES = 4,
   parameter bit          ENHANCED    = 1'b1,
   localparam int unsigned NCH        = NUM_CHIPS * CHANS_PER_CHIP,
   localparam int unsigned NUM_RATES  = NUM_DECADES + 1
) (
   input  logic                  clk_i,
   input  logic                  rst_n_i,
   input  logic [NCH*CODE_W-1:0] clk_sel_i,
   input  logic [NCH*CODE_W-1:0] gat_sel_i,
   input  logic [NCH-1:0]        clk_pin_i,
   input  logic [NCH-1:0]        gat_pin_i,
   input  logic [NUM_CHIPS-1:0]  ext_clk_i,
   input  logic [NCH-1:0]        ctr_out_i,
   input  logic                  pat_present_i,
   input  logic                  pat_clr_i,
   output logic [NCH-1:0]        cnt_clk_o,
   output logic [NCH-1:0]        cnt_gate_o,
   output logic [NCH-1:0]        clk_pin_oe_o,
   output logic [NCH-1:0]        gat_pin_oe_o
);
   if (NUM_CHIPS < 1) begin : g_chk_chips
      $error("ctr_src_router: NUM_CHIPS must be at least 1");
   end
   if (CODE_W < 4) begin : g_chk_code
      $error("ctr_src_router: CODE_W must be at least 4");
   end
   if (NUM_RATES > MAX_RATES) begin : g_chk_rates
      $error("ctr_src_router: at most four decade stages fit the code space");
   end
   if (FIRST_DIV < 2 || DECADE_DIV < 2) begin : g_chk_div
      $error("ctr_src_router: divide ratios must be at least 2");
   end

   logic [NUM_RATES-1:0] rate_tick;
   logic                 pat_occ, pat_left;

   ctr_rate_gen #(
      .FIRST_DIV  (FIRST_DIV),
      .DECADE_DIV (DECADE_DIV),
      .NUM_DECADES(NUM_DECADES)
   ) u_rates (
      .clk_i  (clk_i),
      .rst_n_i(rst_n_i),
      .tick_o (rate_tick)
   );

   ctr_pat_latch u_pat (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .pat_present_i(pat_present_i),
      .clr_i        (pat_clr_i),
      .occ_o        (pat_occ),
      .left_o       (pat_left)
   );

   for (genvar chip = 0; chip < NUM_CHIPS; chip++) begin : g_chip
      localparam int unsigned PREV_CHIP = (chip + NUM_CHIPS - 1) % NUM_CHIPS;
      for (genvar k = 0; k < CHANS_PER_CHIP; k++) begin : g_ch
         localparam int unsigned C  = chip * CHANS_PER_CHIP + k;
         localparam int unsigned N1 = (k > 0) ? C - 1
                                              : PREV_CHIP * CHANS_PER_CHIP + 2;
         localparam int unsigned N2 = (k == 2) ? chip * CHANS_PER_CHIP
                                               : PREV_CHIP * CHANS_PER_CHIP + k + 1;
         ctr_chan_mux #(
            .CODE_W   (CODE_W),
            .NUM_RATES(NUM_RATES),
            .ENHANCED (ENHANCED)
         ) u_mux (
            .clk_sel_i    (clk_sel_i[C*CODE_W +: CODE_W]),
            .gat_sel_i    (gat_sel_i[C*CODE_W +: CODE_W]),
            .pin_clk_i    (clk_pin_i[C]),
            .pin_gat_i    (gat_pin_i[C]),
            .ext_clk_i    (ext_clk_i[chip]),
            .prev_out_i   (ctr_out_i[N1]),
            .prev2_out_i  (ctr_out_i[N2]),
            .rate_tick_i  (rate_tick),
            .pat_present_i(pat_present_i),
            .pat_occ_i    (pat_occ),
            .pat_gone_n_i (~pat_left),
            .clk_o        (cnt_clk_o[C]),
            .gate_o       (cnt_gate_o[C]),
            .clk_oe_o     (clk_pin_oe_o[C]),
            .gat_oe_o     (gat_pin_oe_o[C])
         );
      end
   end
endmodule

// File: rtl/ctr_src_router_chk.sv
module ctr_src_router_chk #(
   parameter int unsigned NUM_RATES = 5
) (
   input logic                 clk_i,
   input logic                 rst_n_i,
   input logic                 pat_present_i,
   input logic                 pat_clr_i,
   input logic                 occ_i,
   input logic                 left_i,
   input logic [NUM_RATES-1:0] tick_i
);
   AST_OCC_SET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (pat_present_i && !pat_clr_i) |=> occ_i);                 // R10
   AST_OCC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (occ_i && !pat_clr_i) |=> occ_i);                         // R10
   AST_LEFT_SET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (occ_i && !pat_present_i && !pat_clr_i) |=> left_i);      // R11
   AST_LEFT_NEEDS_OCC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      left_i |-> occ_i);                                        // R11
   AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      pat_clr_i |=> (!occ_i && !left_i));                       // R12
   AST_FAST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      tick_i[0] |=> !tick_i[0]);                                // R2
   for (genvar i = 1; i < NUM_RATES; i++) begin : g_nest
      AST_TICK_NESTED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         tick_i[i] |-> tick_i[i-1]);                            // R2
   end
endmodule

bind ctr_src_router ctr_src_router_chk #(.NUM_RATES(NUM_DECADES + 1)) u_chk (
   .clk_i        (clk_i),
   .rst_n_i      (rst_n_i),
   .pat_present_i(pat_present_i),
   .pat_clr_i    (pat_clr_i),
   .occ_i        (pat_occ),
   .left_i       (pat_left),
   .tick_i       (rate_tick)
);

// File: tb/ctr_src_router_tb.sv
module ctr_src_router_tb_top;
   localparam int NCHIP = 2;
   localparam int NCH   = NCHIP * 3;
   localparam int CW    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH*CW-1:0] clk_sel = '0, gat_sel = '0;
   logic [NCH-1:0] clk_pin = '0, gat_pin = '0, ctr_out = '0;
   logic [NCHIP-1:0] ext_clk = '0;
   logic pat_present = 1'b0, pat_clr = 1'b0;
   logic [NCH-1:0] cnt_clk, cnt_gate, clk_oe, gat_oe;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      string tag;
      int    ch;
      int    kind;   // 0 clock, 1 gate, 2 clock pin oe, 3 gate pin oe
      logic  exp;
   } item_t;
   item_t sb_q[$];

   always #2 clk = ~clk;

   ctr_src_router dut_i (
      .clk_i(clk), .rst_n_i(rst_n),
      .clk_sel_i(clk_sel), .gat_sel_i(gat_sel),
      .clk_pin_i(clk_pin), .gat_pin_i(gat_pin), .ext_clk_i(ext_clk),
      .ctr_out_i(ctr_out), .pat_present_i(pat_present), .pat_clr_i(pat_clr),
      .cnt_clk_o(cnt_clk), .cnt_gate_o(cnt_gate),
      .clk_pin_oe_o(clk_oe), .gat_pin_oe_o(gat_oe)
   );

   function automatic int nb1(int c);
      return (c % 3 != 0) ? c - 1 : (((c / 3) + NCHIP - 1) % NCHIP) * 3 + 2;
   endfunction
   function automatic int nb2(int c);
      return (c % 3 == 2) ? c - 2 : (((c / 3) + NCHIP - 1) % NCHIP) * 3 + (c % 3) + 1;
   endfunction

   task automatic set_all(int ck, int gt);
      for (int c = 0; c < NCH; c++) begin
         clk_sel[c*CW +: CW] = CW'(ck);
         gat_sel[c*CW +: CW] = CW'(gt);
      end
   endtask

   task automatic expect_bit(string tag, int ch, int kind, logic exp);
      item_t it;
      it.tag = tag; it.ch = ch; it.kind = kind; it.exp = exp;
      sb_q.push_back(it);
   endtask

   // monitor: pops expectations and compares against the outputs
   initial begin
      forever begin
         item_t it;
         logic act;
         wait (sb_q.size() != 0);
         it = sb_q.pop_front();
         case (it.kind)
            0: act = cnt_clk[it.ch];
            1: act = cnt_gate[it.ch];
            2: act = clk_oe[it.ch];
            default: act = gat_oe[it.ch];
         endcase
         n_tests++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s ch%0d kind%0d actual=%b expected=%b",
                     it.tag, it.ch, it.kind, act, it.exp);
         end
      end
   end

   task automatic check_int(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic measure_period(string tag, int code, int exp);
      int gap = 0;
      int lim = 0;
      logic seen_low = 1'b0;
      @(negedge clk);
      clk_sel[0 +: CW] = CW'(code);
      @(negedge clk);
      while (cnt_clk[0] !== 1'b1 && lim < 50000) begin @(negedge clk); lim++; end
      do begin
         @(negedge clk);
         gap++;
         if (cnt_clk[0] !== 1'b1) seen_low = 1'b1;
      end while (cnt_clk[0] !== 1'b1 && gap < 50000);
      check_int(tag, gap, exp);
      if (exp > 1) check_int({tag, " pulse width"}, int'(seen_low), 1);
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state, all codes 0 (R1, R5, R13)
      step(); clk_pin = 6'b101010; #1;
      for (int c = 0; c < NCH; c++) begin
         expect_bit("R1 reset pin clock", c, 0, clk_pin[c]);
         expect_bit("R5 reset gate on", c, 1, 1'b1);
         expect_bit("R13 reset clk oe", c, 2, 1'b0);
         expect_bit("R13 reset gat oe", c, 3, 1'b1);
      end

      // R1: shared external clock per chip
      step(); set_all(7, 2); ext_clk = 2'b10; gat_pin = 6'b010011; #1;
      for (int c = 0; c < NCH; c++) begin
         expect_bit("R1 ext clock", c, 0, ext_clk[c/3]);
         expect_bit("R5 gate pin", c, 1, gat_pin[c]);
         expect_bit("R13 clk oe code7", c, 2, 1'b1);
         expect_bit("R13 gat oe code2", c, 3, 1'b0);
      end
      step(); set_all(9, 6); #1;
      for (int c = 0; c < NCH; c++) begin
         expect_bit("R6 inverted gate pin", c, 1, ~gat_pin[c]);
         expect_bit("R3 clock low", c, 0, 1'b0);
      end
      step(); set_all(8, 1); #1;
      for (int c = 0; c < NCH; c++) begin
         expect_bit("R5 gate off", c, 1, 1'b0);
         expect_bit("R3 clock high", c, 0, 1'b1);
      end

      // R8 / R9: ring neighbours with a walking one
      for (int j = 0; j < NCH; j++) begin
         step(); set_all(6, 3); ctr_out = NCH'(1) << j; #1;
         for (int c = 0; c < NCH; c++) begin
            expect_bit("R8 prev out clock", c, 0, nb1(c) == j);
            expect_bit("R9 inverted out n-2", c, 1, nb2(c) != j);
         end
         step(); set_all(6, 7); #1;
         for (int c = 0; c < NCH; c++)
            expect_bit("R9 out n-2", c, 1, nb2(c) == j);
      end

      // R4: undefined codes give 0 with all pins high
      step(); clk_pin = '1; gat_pin = '1; ext_clk = '1; ctr_out = '1; pat_present = 1'b1;
      for (int code = 12; code < 32; code++) begin
         step(); set_all(code, (code < 14) ? 4 : code); #1;
         expect_bit("R4 clock reserved", code % NCH, 0, 1'b0);
         expect_bit("R4 gate reserved", code % NCH, 1, 1'b0);
      end
      step(); set_all(0, 5); #1;
      expect_bit("R4 gate code5", 2, 1, 1'b0);
      step(); pat_present = 1'b0; set_all(10, 0); #1;
      expect_bit("R3 clock pattern low", 1, 0, 1'b0);
      step(); pat_present = 1'b1; #1;
      expect_bit("R3 clock pattern high", 1, 0, 1'b1);

      // pattern latches: ch0..5 gate codes 8..13
      step(); pat_present = 1'b0; pat_clr = 1'b1;
      for (int c = 0; c < NCH; c++) gat_sel[c*CW +: CW] = CW'(8 + c);
      step(); pat_clr = 1'b0; #1;
      expect_bit("R12 occ cleared", 1, 1, 1'b0);
      expect_bit("R12 gone high after clear", 2, 1, 1'b1);
      expect_bit("R7 not occ", 4, 1, 1'b1);
      expect_bit("R7 not gone", 5, 1, 1'b0);
      step(); pat_present = 1'b1; #1;
      expect_bit("R7 present", 0, 1, 1'b1);
      expect_bit("R7 not present", 3, 1, 1'b0);
      expect_bit("R10 occ not before edge", 1, 1, 1'b0);
      step(); #1;
      expect_bit("R10 occ set", 1, 1, 1'b1);
      expect_bit("R7 not occ set", 4, 1, 1'b0);
      expect_bit("R11 gone still high", 2, 1, 1'b1);
      step(); pat_present = 1'b0; #1;
      expect_bit("R11 gone before edge", 2, 1, 1'b1);
      step(); #1;
      expect_bit("R11 gone latched low", 2, 1, 1'b0);
      expect_bit("R7 not gone high", 5, 1, 1'b1);
      expect_bit("R10 occ holds", 1, 1, 1'b1);
      step(); pat_present = 1'b1;
      step(); #1;
      expect_bit("R11 gone stays low", 2, 1, 1'b0);
      step(); pat_clr = 1'b1;
      step(); pat_clr = 1'b0; #1;
      expect_bit("R12 clear beats present", 1, 1, 1'b0);
      expect_bit("R12 gone restored", 2, 1, 1'b1);
      step(); #1;
      expect_bit("R10 re-arm", 1, 1, 1'b1);

      // R2 / R3: rate periods on channel 0
      measure_period("R3 20MHz period", 11, 1);
      measure_period("R2 10MHz period", 1, 2);
      measure_period("R2 1MHz period", 2, 20);
      measure_period("R2 100kHz period", 3, 200);
      measure_period("R2 10kHz period", 4, 2000);
      measure_period("R2 1kHz period", 5, 20000);

      step(); step();
      finish_run();
   end
endmodule